// File: doc/BRIEF.md
# Mask-Driven Line Compaction and Expansion Unit

This unit reorders one line of an 8x8 block (a column on the first pass, a row on the second) according to an object mask that arrives with the line. Mask bit j marks sample j as inside the object. In the forward direction, the samples inside the object move to the low-index end of the line. A column therefore packs toward its top and a row packs toward its left. The samples keep their order, and the lanes left over are cleared. In the inverse direction, the unit undoes that packing: it takes the first N samples of the line and writes them back to the lanes the mask marks, again in order, and clears every other lane.

The mask changes from line to line, so the routing is worked out again for every line. It is not a fixed shift. The unit reports N, the number of samples inside the object, beside the reordered line, and that value sets the length of the variable-length transform that follows. Lines enter and leave through valid/ready handshakes. There is one register stage, so a line accepted in one cycle is presented in the next while the output side is ready.

Top module: `mask_align_unit`

## Requirements
- R1: After reset, out_valid is low and in_ready is high.
- R2: With in_inverse=0, the sample at the k-th set mask bit, counting from bit 0, appears on output lane k, for k from 0 to N-1.
- R3: With in_inverse=0, output lanes N to 7 are zero.
- R4: With in_inverse=1, output lane j, when mask bit j is set, carries input lane r, where r is the number of set mask bits below j. A forward pass followed by an inverse pass with the same mask restores every masked sample.
- R5: With in_inverse=1, output lanes whose mask bit is clear are zero.
- R6: out_count equals the number of set bits in the line's mask, from 0 to 8.
- R7: An all-zero mask gives all-zero lanes and out_count=0. An all-ones mask passes the line through unchanged in both directions.
- R8: A line accepted while out_ready is high is presented with out_valid high on the next cycle. in_ready is high whenever out_ready is high.
- R9: While out_valid is high and out_ready is low, in_ready is low and out_data and out_count hold their values. A line offered during that time is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | An input line is offered |
| in_ready | output | 1 | The unit takes the offered line at this edge |
| in_data | input | LANES*DW | Signed samples; lane j at bits j*DW +: DW |
| in_mask | input | LANES | Object mask; bit j belongs to lane j |
| in_inverse | input | 1 | 0 packs the line, 1 expands it |
| out_valid | output | 1 | An output line is held |
| out_ready | input | 1 | The downstream side takes the held line |
| out_data | output | LANES*DW | Reordered samples, laid out like in_data |
| out_count | output | $clog2(LANES+1) | Number of mask bits set in the line |

## Verification
The bench builds the unit with its defaults: LANES=8 and DW=12. With 8 lanes there are only 256 masks, so every mask is driven in both directions, each one with its own signed data pattern. That covers every pack and scatter arrangement, the empty mask and the full mask. Expected lanes come from a pointer walk in the bench. The sweep runs with the output side always ready, then a stall sequence checks holding and refusal, and forward/inverse round trips check that masked samples come back intact.

// File: rtl/mau_pkg.sv
package mau_pkg;
  localparam int unsigned MAU_MAX_LANES = 16;

  // number of set bits of m strictly below position upto
  function automatic int unsigned mau_ones_below(input logic [MAU_MAX_LANES-1:0] m,
                                                 input int unsigned upto);
    int unsigned cnt;
    cnt = 0;
    for (int unsigned i = 0; i < MAU_MAX_LANES; i++) begin
      if (i < upto && m[i]) cnt = cnt + 1;
    end
    return cnt;
  endfunction
endpackage

// File: rtl/mau_rank.sv
module mau_rank #(
  parameter int unsigned LANES = 8,
  localparam int unsigned IW = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int unsigned CW = $clog2(LANES + 1)
) (
  input  logic [LANES-1:0]    mask,
  output logic [LANES*IW-1:0] rank,
  output logic [CW-1:0]       count
);
  import mau_pkg::*;

  logic [MAU_MAX_LANES-1:0] mask_wide;
  assign mask_wide = MAU_MAX_LANES'(mask);

  for (genvar j = 0; j < LANES; j++) begin : g_rank
    assign rank[j*IW +: IW] = IW'(mau_ones_below(mask_wide, j));
  end

  assign count = CW'(mau_ones_below(mask_wide, LANES));
endmodule

// File: rtl/mau_route.sv
module mau_route #(
  parameter int unsigned LANES = 8,
  parameter int unsigned DW    = 12,
  localparam int unsigned IW = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [LANES*DW-1:0] data,
  input  logic [LANES-1:0]    mask,
  input  logic [LANES*IW-1:0] rank,
  input  logic                inverse,
  output logic [LANES*DW-1:0] routed
);
  logic [LANES*DW-1:0] packed_line;
  logic [LANES*DW-1:0] spread_line;

  for (genvar k = 0; k < LANES; k++) begin : g_pack
    logic [DW-1:0] acc;
    always_comb begin
      acc = '0;
      for (int j = 0; j < LANES; j++) begin
        if (mask[j] && rank[j*IW +: IW] == IW'(k)) acc = acc | data[j*DW +: DW];
      end
    end
    assign packed_line[k*DW +: DW] = acc;
  end

  for (genvar j = 0; j < LANES; j++) begin : g_spread
    logic [IW-1:0] src;
    assign src = rank[j*IW +: IW];
    assign spread_line[j*DW +: DW] = mask[j] ? data[src*DW +: DW] : '0;
  end

  assign routed = inverse ? spread_line : packed_line;
endmodule

// File: rtl/mau_stage.sv
module mau_stage #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         valid_i,
  output logic         ready_o,
  input  logic [W-1:0] d,
  output logic         valid_o,
  input  logic         ready_i,
  output logic [W-1:0] q
);
  logic         full_q;
  logic [W-1:0] hold_q;

  assign ready_o = !full_q || ready_i;
  assign valid_o = full_q;
  assign q       = hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      hold_q <= '0;
    end else begin
      if (ready_o) full_q <= valid_i;
      if (valid_i && ready_o) hold_q <= d;
    end
  end
endmodule

// File: rtl/mask_align_unit.sv
module mask_align_unit #(
  parameter int unsigned LANES = 8,
  parameter int unsigned DW    = 12,
  localparam int unsigned IW = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int unsigned CW = $clog2(LANES + 1),
  localparam int unsigned PW = CW + 1 + LANES + LANES*DW
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [LANES*DW-1:0] in_data,
  input  logic [LANES-1:0]    in_mask,
  input  logic                in_inverse,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [LANES*DW-1:0] out_data,
  output logic [CW-1:0]       out_count
);
  logic [LANES*IW-1:0] line_rank;
  logic [CW-1:0]       line_count;
  logic [LANES*DW-1:0] line_routed;
  logic [PW-1:0]       stage_d;
  logic [PW-1:0]       stage_q;

  // named events and held state for the checker
  logic                take_line;
  logic [LANES-1:0]    held_mask;
  logic                held_inverse;

  mau_rank #(.LANES(LANES)) u_rank (
    .mask  (in_mask),
    .rank  (line_rank),
    .count (line_count)
  );

  mau_route #(.LANES(LANES), .DW(DW)) u_route (
    .data    (in_data),
    .mask    (in_mask),
    .rank    (line_rank),
    .inverse (in_inverse),
    .routed  (line_routed)
  );

  assign stage_d = {line_count, in_inverse, in_mask, line_routed};

  mau_stage #(.W(PW)) u_stage (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid_i (in_valid),
    .ready_o (in_ready),
    .d       (stage_d),
    .valid_o (out_valid),
    .ready_i (out_ready),
    .q       (stage_q)
  );

  assign take_line    = in_valid && in_ready;
  assign out_data     = stage_q[LANES*DW-1:0];
  assign held_mask    = stage_q[LANES*DW +: LANES];
  assign held_inverse = stage_q[LANES*DW + LANES];
  assign out_count    = stage_q[PW-1 -: CW];
endmodule

// File: rtl/mau_checker.sv
module mau_checker #(
  parameter int unsigned LANES = 8,
  parameter int unsigned DW    = 12,
  localparam int unsigned CW = $clog2(LANES + 1)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                take_line,
  input logic                in_ready,
  input logic                out_valid,
  input logic                out_ready,
  input logic [LANES*DW-1:0] out_data,
  input logic [CW-1:0]       out_count,
  input logic [LANES-1:0]    held_mask,
  input logic                held_inverse
);
  assert_accept_presents_R8: assert property (@(posedge clk) disable iff (!rst_n)
    take_line |=> out_valid);

  assert_ready_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_ready |-> in_ready);

  assert_stall_refuses_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  assert_stall_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_count)));

  assert_count_matches_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (32'(out_count) == 32'($countones(held_mask))));

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assert_pack_tail_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !held_inverse && (32'(out_count) <= k)) |-> (out_data[k*DW +: DW] == '0));

    assert_spread_gap_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && held_inverse && !held_mask[k]) |-> (out_data[k*DW +: DW] == '0));
  end
endmodule

bind mask_align_unit mau_checker #(.LANES(LANES), .DW(DW)) i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .take_line    (take_line),
  .in_ready     (in_ready),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_data     (out_data),
  .out_count    (out_count),
  .held_mask    (held_mask),
  .held_inverse (held_inverse)
);

// File: tb/test_mask_align_unit.sv
module test_mask_align_unit;
  localparam int L  = 8;
  localparam int DW = 12;
  localparam int CW = $clog2(L + 1);

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic            in_ready;
  logic [L*DW-1:0] in_data = '0;
  logic [L-1:0]    in_mask = '0;
  logic            in_inverse = 1'b0;
  logic            out_valid;
  logic            out_ready = 1'b1;
  logic [L*DW-1:0] out_data;
  logic [CW-1:0]   out_count;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  mask_align_unit #(.LANES(L), .DW(DW)) i_mask_align_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_mask(in_mask), .in_inverse(in_inverse),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_count(out_count)
  );

  task automatic check(input bit ok, input string req, input logic [L*DW-1:0] act,
                       input logic [L*DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [L*DW-1:0] pattern(input int p);
    logic [L*DW-1:0] v;
    for (int j = 0; j < L; j++) v[j*DW +: DW] = DW'((p * 613 + j * 1559 + 2049) % 4096);
    return v;
  endfunction

  // pointer walk: pack or spread
  function automatic logic [L*DW-1:0] model(input logic [L*DW-1:0] d, input logic [L-1:0] m,
                                            input bit inv);
    logic [L*DW-1:0] e;
    int ptr;
    e = '0;
    ptr = 0;
    for (int j = 0; j < L; j++) begin
      if (m[j]) begin
        if (inv) e[j*DW +: DW] = d[ptr*DW +: DW];
        else     e[ptr*DW +: DW] = d[j*DW +: DW];
        ptr++;
      end
    end
    return e;
  endfunction

  function automatic int ones(input logic [L-1:0] m);
    int c;
    c = 0;
    for (int j = 0; j < L; j++) c += int'(m[j]);
    return c;
  endfunction

  // drive one line with out_ready high, return output one cycle later
  task automatic run_line(input logic [L*DW-1:0] d, input logic [L-1:0] m, input bit inv,
                          output logic [L*DW-1:0] got);
    @(negedge clk);
    check(in_ready === 1'b1, "R8 in_ready", L*DW'(in_ready), L*DW'(1));
    in_valid = 1'b1; in_data = d; in_mask = m; in_inverse = inv; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid === 1'b1, "R8 out_valid", L*DW'(out_valid), L*DW'(1));
    got = out_data;
  endtask

  initial begin
    logic [L*DW-1:0] got;
    logic [L*DW-1:0] exp;
    logic [L*DW-1:0] first;
    logic [L*DW-1:0] mid;
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0, "R1 out_valid", L*DW'(out_valid), '0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid === 1'b0 && in_ready === 1'b1, "R1 idle", L*DW'({out_valid, in_ready}), L*DW'(1));

    // full sweep of masks in both directions
    for (int inv = 0; inv < 2; inv++) begin
      for (int m = 0; m < 256; m++) begin
        logic [L*DW-1:0] d;
        d = pattern(m + inv * 300);
        run_line(d, L'(m), bit'(inv), got);
        exp = model(d, L'(m), bit'(inv));
        check(got === exp, inv ? "R4/R5 spread" : "R2/R3 pack", got, exp);
        check(int'(out_count) == ones(L'(m)), "R6 count", L*DW'(out_count), L*DW'(ones(L'(m))));
        if (m == 0) check(got === '0 && out_count == 0, "R7 empty", got, '0);
        if (m == 255) check(got === d, "R7 full passthrough", got, d);
      end
    end

    // round trips: pack then spread restores masked samples
    for (int t = 0; t < 24; t++) begin
      logic [L-1:0] m;
      logic [L*DW-1:0] d;
      m = L'(t * 37 + 5);
      d = pattern(t + 900);
      run_line(d, m, 1'b0, mid);
      run_line(mid, m, 1'b1, got);
      exp = '0;
      for (int j = 0; j < L; j++) if (m[j]) exp[j*DW +: DW] = d[j*DW +: DW];
      check(got === exp, "R4 round trip", got, exp);
    end

    // stall: hold output, refuse a second line
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_data = pattern(1234); in_mask = 8'b1010_0110; in_inverse = 1'b0;
    @(negedge clk);
    first = model(pattern(1234), 8'b1010_0110, 1'b0);
    in_data = pattern(4321); in_mask = 8'b0101_1001; in_inverse = 1'b1;
    for (int c = 0; c < 4; c++) begin
      check(out_valid === 1'b1 && out_data === first, "R9 hold", out_data, first);
      check(in_ready === 1'b0, "R9 refuse", L*DW'(in_ready), '0);
      check(out_count == 4, "R9 count held", L*DW'(out_count), L*DW'(4));
      @(negedge clk);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    exp = model(pattern(4321), 8'b0101_1001, 1'b1);
    check(out_valid === 1'b1 && out_data === exp, "R9 release", out_data, exp);
    @(negedge clk);
    check(out_valid === 1'b0, "R8 drains", L*DW'(out_valid), '0);

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule